// File: doc/BRIEF.md
# Word-to-Chain Scan Stimulus Distributor

This block turns full-width stimulus words, arriving over a functional data port, into bit streams for a set of parallel wrapper chains around a core under test. Each accepted word is cut into equal slices, one slice per chain. Every chain then shifts one bit of its slice per clock. A new word is therefore needed once per word period, where the period is the word width divided by the chain count, rounded down.

Word bits above the chain slices feed extra cells at the input end of the chains. These cells are meaningful only for the final word of a pattern. The final word is not shifted at all. It is presented in parallel for direct application to the core-side cells, and a capture strobe follows one cycle later.

The shift length is rounded up to a whole number of words. The word stream carries the padding and the leading dummy bits for shorter chains ahead of the real stimuli. The block only counts words and shift cycles, so every chain finishes loading on the same cycle.

Top module: `stim_distributor`

## Requirements
- R1: The word period is P = floor(W_IN/WC). For an accepted non-final word, chain c receives word bits [c*P +: P], least significant bit first, on `chain_si[c]`. A bit is valid in each cycle where `shift_en` is high, and shift cycles begin the cycle after the handshake.
- R2: A pattern consists of ceil(S_IN/P)+1 words. The first ceil(S_IN/P) words produce exactly ceil(S_IN/P)*P shift cycles in total.
- R3: If no new word is valid when a word's P shift cycles end, `shift_en` stays low and `chain_si` holds its value. No bit is lost or repeated when shifting resumes.
- R4: When words are offered back to back, `in_ready` is high during the last shift cycle of a word, so shifting runs without a gap. The final word's `load_en` then appears exactly ceil(S_IN/P)*P cycles after the first shift cycle of the pattern.
- R5: The final word of a pattern is never shifted. The cycle after it is accepted, `load_en` is high for one cycle and `load_word` equals the whole final word, with shift_en low.
- R6: Remainder bits [W_IN-1 : WC*P] of non-final words have no effect. Chain outputs depend only on the slices, and `load_word` changes only in a cycle where `load_en` is high.
- R7: `capture` is high for exactly one cycle, the cycle right after `load_en`. The word count then restarts, so the next accepted word is the first shift word of a new pattern.
- R8: `in_ready` is low while `load_en` or `capture` is high.
- R9: After synchronous reset, `shift_en`, `load_en` and `capture` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stimulus word offered |
| in_data | input | W_IN | Stimulus word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| chain_si | output | WC | Scan-in bit per wrapper chain |
| shift_en | output | 1 | Chains shift this cycle |
| load_word | output | W_IN | Final word of a pattern, for direct application |
| load_en | output | 1 | load_word is new this cycle |
| capture | output | 1 | Launch/capture strobe |

## Verification
The assertions assume that in_valid and in_data are driven only away from the clock edge. They also assume that a word, once offered, is held until it is taken. The bench always drives at the falling edge and holds each word until in_ready was high at a rising edge. Patterns mix gapless delivery, long gaps that force stalls, and random gaps. Remainder bits are filled with random values, so any leak of them into a chain or into load_word shows up.

// File: rtl/stim_dist_pkg.sv
package stim_dist_pkg;
  function automatic int unsigned div_ceil(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/stim_slicer.sv
module stim_slicer #(
  parameter int unsigned WC = 10,
  parameter int unsigned P  = 3,
  parameter int unsigned BW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [BW-1:0]    adv_idx,
  input  logic [WC*P-1:0]  slices,
  output logic [WC-1:0]    chain_si
);
  for (genvar c = 0; c < WC; c++) begin : g_chain
    logic [P-1:0] seg_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q       <= '0;
        chain_si[c] <= 1'b0;
      end else if (load) begin
        seg_q       <= slices[c*P +: P];
        chain_si[c] <= slices[c*P];
      end else if (adv) begin
        chain_si[c] <= seg_q[adv_idx];
      end
    end
  end
endmodule

// File: rtl/stim_sequencer.sv
module stim_sequencer #(
  parameter int unsigned P       = 3,
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned BW      = 2,
  parameter int unsigned WW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          shift_load,
  output logic          final_acc,
  output logic          adv,
  output logic [BW-1:0] adv_idx,
  output logic          shift_en,
  output logic          load_en,
  output logic          capture
);
  localparam logic [BW-1:0] LAST_BIT  = BW'(P - 1);
  localparam logic [WW-1:0] LAST_WORD = WW'(N_WORDS - 1);

  logic [BW-1:0] bit_q;
  logic [WW-1:0] word_q;
  logic          last_bit, acc;

  assign last_bit   = (bit_q == LAST_BIT);
  assign in_ready   = !load_en && !capture && (!shift_en || last_bit);
  assign acc        = in_valid && in_ready;
  assign final_acc  = acc && (word_q == LAST_WORD);
  assign shift_load = acc && (word_q != LAST_WORD);
  assign adv        = shift_en && !last_bit;
  assign adv_idx    = bit_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= '0;
      word_q   <= '0;
      shift_en <= 1'b0;
      load_en  <= 1'b0;
      capture  <= 1'b0;
    end else begin
      capture <= load_en;
      load_en <= final_acc;
      if (final_acc) begin
        word_q   <= '0;
        shift_en <= 1'b0;
      end else if (shift_load) begin
        word_q   <= word_q + 1'b1;
        bit_q    <= '0;
        shift_en <= 1'b1;
      end else if (adv) begin
        bit_q <= adv_idx;
      end else if (shift_en) begin
        shift_en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stim_direct_stage.sv
module stim_direct_stage #(
  parameter int unsigned W_IN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [W_IN-1:0] word,
  output logic [W_IN-1:0] load_word
);
  always_ff @(posedge clk) begin
    if (rst)       load_word <= '0;
    else if (take) load_word <= word;
  end
endmodule

// File: rtl/stim_distributor.sv
module stim_distributor
  import stim_dist_pkg::*;
#(
  parameter int unsigned W_IN = 32,
  parameter int unsigned WC   = 10,
  parameter int unsigned S_IN = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W_IN-1:0] in_data,
  output logic            in_ready,
  output logic [WC-1:0]   chain_si,
  output logic            shift_en,
  output logic [W_IN-1:0] load_word,
  output logic            load_en,
  output logic            capture
);
  localparam int unsigned P       = W_IN / WC;
  localparam int unsigned N_SHIFT = div_ceil(S_IN, P);
  localparam int unsigned N_WORDS = N_SHIFT + 1;
  localparam int unsigned BW      = idx_width(P);
  localparam int unsigned WW      = idx_width(N_WORDS);

  logic          shift_load, final_acc, adv;
  logic [BW-1:0] adv_idx;

  stim_sequencer #(.P(P), .N_WORDS(N_WORDS), .BW(BW), .WW(WW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .shift_load(shift_load), .final_acc(final_acc), .adv(adv),
    .adv_idx(adv_idx), .shift_en(shift_en), .load_en(load_en),
    .capture(capture)
  );

  stim_slicer #(.WC(WC), .P(P), .BW(BW)) u_slice (
    .clk(clk), .rst(rst), .load(shift_load), .adv(adv), .adv_idx(adv_idx),
    .slices(in_data[WC*P-1:0]), .chain_si(chain_si)
  );

  stim_direct_stage #(.W_IN(W_IN)) u_direct (
    .clk(clk), .rst(rst), .take(final_acc), .word(in_data),
    .load_word(load_word)
  );
endmodule

// File: rtl/stim_distributor_chk.sv
module stim_distributor_chk #(
  parameter int unsigned W_IN = 32,
  parameter int unsigned WC   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic [WC-1:0]   chain_si,
  input logic            shift_en,
  input logic [W_IN-1:0] load_word,
  input logic            load_en,
  input logic            capture
);
  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |-> $stable(chain_si));
  assert_no_shift_on_load_R5: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !shift_en);
  assert_load_single_R5: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !load_en);
  assert_load_word_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !load_en |-> $stable(load_word));
  assert_capture_follows_R7: assert property (@(posedge clk) disable iff (rst)
    load_en |=> capture);
  assert_capture_cause_R7: assert property (@(posedge clk) disable iff (rst)
    capture |-> $past(load_en));
  assert_ready_low_R8: assert property (@(posedge clk) disable iff (rst)
    (load_en || capture) |-> !in_ready);
endmodule

bind stim_distributor stim_distributor_chk #(.W_IN(W_IN), .WC(WC)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .chain_si(chain_si),
  .shift_en(shift_en), .load_word(load_word), .load_en(load_en),
  .capture(capture)
);

// File: tb/tb_stim_distributor.sv
module tb_stim_distributor;
  localparam int W_IN = 32, WC = 10, S_IN = 7;
  localparam int P = W_IN / WC;
  localparam int N_SHIFT = (S_IN + P - 1) / P;
  localparam int S_PAD = N_SHIFT * P;
  localparam int N_WORDS = N_SHIFT + 1;
  localparam int NPAT = 24;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [W_IN-1:0] in_data = '0;
  logic in_ready, shift_en, load_en, capture;
  logic [WC-1:0] chain_si;
  logic [W_IN-1:0] load_word;

  int checks = 0, errors = 0;
  logic [W_IN-1:0] words [NPAT][N_WORDS];
  int pat = 0, sidx = 0, cyc = 0, first_cyc = -1, caps = 0;
  bit done = 0, mon_on = 0;
  logic [WC-1:0] prev_si;
  logic [W_IN-1:0] prev_lw;
  logic prev_load = 0;

  stim_distributor #(.W_IN(W_IN), .WC(WC), .S_IN(S_IN)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(int p, int k, int c);
    return words[p][k / P][c*P + (k % P)];
  endfunction

  function automatic int gap_for(int p);
    if (p == 0 || p == 2) return 0;
    if (p == 1) return 5;
    return $urandom_range(0, 3);
  endfunction

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (mon_on && !done) begin
      if (shift_en) begin
        if (sidx == 0) first_cyc = cyc;
        for (int c = 0; c < WC; c++)
          check(chain_si[c] === exp_bit(pat, sidx, c), "R1 chain bit", chain_si[c], exp_bit(pat, sidx, c));
        sidx++;
        check(sidx <= S_PAD, "R2 shift count bound", sidx, S_PAD);
      end else begin
        check(chain_si === prev_si, "R3 hold on stall", chain_si, prev_si);
      end
      if (!load_en) check(load_word === prev_lw, "R6 load_word stable", load_word, prev_lw);
      if (load_en || capture) check(!in_ready, "R8 ready low", in_ready, 0);
      if (load_en) begin
        check(!shift_en, "R5 no shift on final word", shift_en, 0);
        check(load_word === words[pat][N_WORDS-1], "R5 R6 load_word", load_word, words[pat][N_WORDS-1]);
        check(sidx == S_PAD, "R2 shift cycles per pattern", sidx, S_PAD);
        if (pat == 0 || pat == 2)
          check(cyc - first_cyc == S_PAD, "R4 gapless timing", cyc - first_cyc, S_PAD);
      end
      check(capture === prev_load, "R7 capture after load", capture, prev_load);
      if (capture) begin
        caps++;
        sidx = 0;
        pat++;
        if (pat == NPAT) done = 1;
      end
      prev_si = chain_si;
      prev_lw = load_word;
      prev_load = load_en;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int p = 0; p < NPAT; p++)
      for (int w = 0; w < N_WORDS; w++)
        words[p][w] = (p == 2) ? '1 : $urandom();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    check(!shift_en && !load_en && !capture && in_ready, "R9 reset state",
          {shift_en, load_en, capture, in_ready}, 4'b0001);
    prev_si = chain_si; prev_lw = load_word; prev_load = 0;
    mon_on = 1;
    for (int p = 0; p < NPAT; p++) begin
      for (int w = 0; w < N_WORDS; w++) begin
        int g = gap_for(p);
        repeat (g) @(negedge clk);
        in_valid = 1;
        in_data = words[p][w];
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        in_data = $urandom();
      end
    end
    repeat (10) @(negedge clk);
    check(caps == NPAT, "R7 pattern count", caps, NPAT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule